// File: doc/BRIEF.md
# Bypass-Mode Test Clock Generator

This block produces the output clocks of a phase-locked clock driver when its oscillator loop is switched off for slow board-level testing. When the loop-enable input is low, the block leaves the oscillator outputs unused. It builds a double-rate clock, a set of identical main clocks and a half-rate clock from one of two sync inputs, which a reference-select input picks. A frequency-select input sets the divide ratio of each output. The double-rate output can also be the plain inverse of the sync input. Because no loop has to lock, the sync input may run at any rate, including well below 1 MHz.

When the loop-enable input is high, every output carries the matching loop-mode input. Those inputs stand in for the real oscillator outputs. The divider is a set of flip-flops clocked on the falling edge of the selected sync. A synchronous active-high reset, sampled on that same falling edge, clears the divider so that every divided output starts low.

Top module: `tcd_test_clkgen`

## Requirements
- R1: With `ref_sel` = 0 the divider and outputs follow `sync0`; with `ref_sel` = 1 they follow `sync1`.
- R2: With `pll_en` = 1, `dbl_q`, `main_q` and `half_q` equal `pll_dbl`, `pll_main` and `pll_half` respectively.
- R3: With `pll_en` = 0 and `fsel` = 1, `dbl_q` is the logical inverse of the selected sync.
- R4: With `pll_en` = 0 and `fsel` = 1, `main_q` is the selected sync divided by 2 and `half_q` is the selected sync divided by 4.
- R5: With `pll_en` = 0 and `fsel` = 0, `dbl_q` is sync divided by 2, `main_q` is sync divided by 4 and `half_q` is sync divided by 8.
- R6: Every divided output changes only at a falling edge of the selected sync. If the k-th falling edge after reset is counted as k, then divide-by-2 equals bit 0 of k, divide-by-4 bit 1 and divide-by-8 bit 2.
- R7: `rst` high at a falling edge of the selected sync clears the divider, so in test mode every divided output is 0 afterwards.
- R8: All bits of `main_q` carry the same value at all times.
- R9: The ratios of R4 and R5 hold for any sync period; two unequal periods are exercised.
- R10: Changing `fsel` or `pll_en` neither clears nor disturbs the divider count; only `rst` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high divider reset, sampled on the selected sync falling edge |
| pll_en | input | 1 | 1: loop-mode pass-through, 0: test mode |
| fsel | input | 1 | Frequency select for the test-mode ratios |
| ref_sel | input | 1 | Sync source select: 0 picks sync0, 1 picks sync1 |
| sync0 | input | 1 | Sync input 0 |
| sync1 | input | 1 | Sync input 1 |
| pll_dbl | input | 1 | Placeholder loop-mode double-rate clock |
| pll_main | input | NUM_MAIN | Placeholder loop-mode main clocks |
| pll_half | input | 1 | Placeholder loop-mode half-rate clock |
| dbl_q | output | 1 | Double-rate output |
| main_q | output | NUM_MAIN | Main outputs |
| half_q | output | 1 | Half-rate output |

## Verification
Two things can happen on the same sync falling edge: a divider advance and a change of frequency select or loop enable. The bench flips `fsel` and `pll_en` while the selected sync keeps running. Its behavioural fall counter must then go on matching every output without a restart, which tests R10 against the ratios of R4 and R5. A reset arriving on the same falling edge as a count is also provoked, and the reset must win.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  // One set of output taps, before the loop/test multiplexer.
  typedef struct packed {
    logic dbl;
    logic main;
    logic half;
  } tcd_taps_t;

  // Minimum divider depth: divide-by-8 needs three toggle stages.
  localparam int unsigned TCD_MIN_STAGES = 3;

endpackage

// File: rtl/tcd_src_sel.sv
module tcd_src_sel (
  input  logic ref_sel,
  input  logic sync0,
  input  logic sync1,
  output logic sel_clk
);

  always_comb begin
    sel_clk = ref_sel ? sync1 : sync0;
  end

endmodule

// File: rtl/tcd_div_chain.sv
module tcd_div_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk_n,
  input  logic              rst,
  output logic [STAGES-1:0] stage_q
);

  // Toggle enable of each stage: all lower stages high.
  logic [STAGES-1:0] tog_en;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign tog_en[s] = 1'b1;
      end else begin : g_next
        assign tog_en[s] = tog_en[s-1] & stage_q[s-1];
      end

      always_ff @(negedge clk_n) begin
        if (rst) begin
          stage_q[s] <= 1'b0;
        end else if (tog_en[s]) begin
          stage_q[s] <= ~stage_q[s];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/tcd_out_mux.sv
module tcd_out_mux
  import tcd_pkg::*;
#(
  parameter int unsigned STAGES   = 3,
  parameter int unsigned NUM_MAIN = 5
) (
  input  logic                sel_clk,
  input  logic [STAGES-1:0]   stage_q,
  input  logic                pll_en,
  input  logic                fsel,
  input  logic                pll_dbl,
  input  logic [NUM_MAIN-1:0] pll_main,
  input  logic                pll_half,
  output logic                dbl_q,
  output logic [NUM_MAIN-1:0] main_q,
  output logic                half_q
);

  tcd_taps_t test_taps;

  always_comb begin
    if (fsel) begin
      test_taps.dbl  = ~sel_clk;
      test_taps.main = stage_q[0];
      test_taps.half = stage_q[1];
    end else begin
      test_taps.dbl  = stage_q[0];
      test_taps.main = stage_q[1];
      test_taps.half = stage_q[2];
    end
  end

  always_comb begin
    dbl_q  = pll_en ? pll_dbl  : test_taps.dbl;
    half_q = pll_en ? pll_half : test_taps.half;
  end

  generate
    for (genvar m = 0; m < NUM_MAIN; m++) begin : g_main
      assign main_q[m] = pll_en ? pll_main[m] : test_taps.main;
    end
  endgenerate

endmodule

// File: rtl/tcd_test_clkgen.sv
module tcd_test_clkgen
  import tcd_pkg::*;
#(
  parameter int unsigned NUM_MAIN = 5
) (
  input  logic                rst,
  input  logic                pll_en,
  input  logic                fsel,
  input  logic                ref_sel,
  input  logic                sync0,
  input  logic                sync1,
  input  logic                pll_dbl,
  input  logic [NUM_MAIN-1:0] pll_main,
  input  logic                pll_half,
  output logic                dbl_q,
  output logic [NUM_MAIN-1:0] main_q,
  output logic                half_q
);

  localparam int unsigned STAGES = TCD_MIN_STAGES;

  logic              sel_clk;
  logic [STAGES-1:0] stage_q;

  tcd_src_sel u_src (
    .ref_sel (ref_sel),
    .sync0   (sync0),
    .sync1   (sync1),
    .sel_clk (sel_clk)
  );

  tcd_div_chain #(.STAGES(STAGES)) u_div (
    .clk_n   (sel_clk),
    .rst     (rst),
    .stage_q (stage_q)
  );

  tcd_out_mux #(.STAGES(STAGES), .NUM_MAIN(NUM_MAIN)) u_mux (
    .sel_clk  (sel_clk),
    .stage_q  (stage_q),
    .pll_en   (pll_en),
    .fsel     (fsel),
    .pll_dbl  (pll_dbl),
    .pll_main (pll_main),
    .pll_half (pll_half),
    .dbl_q    (dbl_q),
    .main_q   (main_q),
    .half_q   (half_q)
  );

endmodule

// File: rtl/tcd_test_clkgen_chk.sv
module tcd_test_clkgen_chk #(
  parameter int unsigned NUM_MAIN = 5
) (
  input logic                rst,
  input logic                pll_en,
  input logic                fsel,
  input logic                ref_sel,
  input logic                sync0,
  input logic                sync1,
  input logic                pll_dbl,
  input logic [NUM_MAIN-1:0] pll_main,
  input logic                pll_half,
  input logic                dbl_q,
  input logic [NUM_MAIN-1:0] main_q,
  input logic                half_q
);

  logic chk_clk;
  logic mode_hi;
  logic mode_lo;

  always_comb begin
    chk_clk = ref_sel ? sync1 : sync0;
    mode_hi = !pll_en && fsel;
    mode_lo = !pll_en && !fsel;
  end

  // R3: just before a sync fall the sync is high, so the inverse is low
  a_r3_dbl_inverse: assert property (@(negedge chk_clk)
    mode_hi |-> (dbl_q == 1'b0));

  // R2: loop mode passes the placeholders through
  a_r2_bypass: assert property (@(negedge chk_clk) disable iff (rst)
    pll_en |-> (dbl_q == pll_dbl && main_q == pll_main && half_q == pll_half));

  // R4: divide-by-2 main flips on every fall
  a_r4_main_toggles: assert property (@(negedge chk_clk) disable iff (rst)
    (mode_hi && $past(mode_hi) && !$past(rst)) |-> (main_q[0] != $past(main_q[0])));

  // R4: divide-by-4 only moves after the divide-by-2 was high
  a_r4_half_follows: assert property (@(negedge chk_clk) disable iff (rst)
    (mode_hi && $past(mode_hi) && !$past(rst) && half_q != $past(half_q))
      |-> $past(main_q[0]));

  // R5: divide-by-2 on the double-rate output flips on every fall
  a_r5_dbl_toggles: assert property (@(negedge chk_clk) disable iff (rst)
    (mode_lo && $past(mode_lo) && !$past(rst)) |-> (dbl_q != $past(dbl_q)));

  // R5: divide-by-8 only moves after divide-by-2 and divide-by-4 were both high
  a_r5_half_follows: assert property (@(negedge chk_clk) disable iff (rst)
    (mode_lo && $past(mode_lo) && !$past(rst) && half_q != $past(half_q))
      |-> ($past(main_q[0]) && $past(dbl_q)));

  // R7: the first fall after a reset fall sees all divided outputs low
  a_r7_reset_clears: assert property (@(negedge chk_clk) disable iff (rst)
    ($past(rst) && mode_lo) |-> (!dbl_q && !main_q[0] && !half_q));

endmodule

bind tcd_test_clkgen tcd_test_clkgen_chk #(.NUM_MAIN(NUM_MAIN)) u_chk (
  .rst      (rst),
  .pll_en   (pll_en),
  .fsel     (fsel),
  .ref_sel  (ref_sel),
  .sync0    (sync0),
  .sync1    (sync1),
  .pll_dbl  (pll_dbl),
  .pll_main (pll_main),
  .pll_half (pll_half),
  .dbl_q    (dbl_q),
  .main_q   (main_q),
  .half_q   (half_q)
);

// File: tb/test_tcd_test_clkgen.sv
`timescale 1ns/1ps
module test_tcd_test_clkgen;

  localparam int NM = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst      = 1'b1;
  logic          pll_en   = 1'b0;
  logic          fsel     = 1'b0;
  logic          ref_sel  = 1'b0;
  logic          sync0    = 1'b0;
  logic          sync1    = 1'b0;
  logic          pll_dbl  = 1'b0;
  logic [NM-1:0] pll_main = '0;
  logic          pll_half = 1'b0;
  logic          dbl_q;
  logic [NM-1:0] main_q;
  logic          half_q;

  tcd_test_clkgen #(.NUM_MAIN(NM)) i_tcd_test_clkgen (
    .rst(rst), .pll_en(pll_en), .fsel(fsel), .ref_sel(ref_sel),
    .sync0(sync0), .sync1(sync1), .pll_dbl(pll_dbl), .pll_main(pll_main),
    .pll_half(pll_half), .dbl_q(dbl_q), .main_q(main_q), .half_q(half_q)
  );

  // Two sync sources of unequal period (8 and 14 clocks)
  int s0_cnt = 0;
  int s1_cnt = 0;
  always @(posedge clk) begin
    s0_cnt <= (s0_cnt == 3) ? 0 : s0_cnt + 1;
    s1_cnt <= (s1_cnt == 6) ? 0 : s1_cnt + 1;
    if (s0_cnt == 3) sync0 <= ~sync0;
    if (s1_cnt == 6) sync1 <= ~sync1;
  end

  int    n_checks = 0;
  int    n_fail   = 0;
  string ctx      = "init";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", tag, ctx, $time, act, exp);
    end
  endtask

  // Behavioural reference: count selected-sync falls since the last reset fall
  logic    prev_sel = 1'b0;
  bit      cnt_ok   = 1'b0;
  int      falls    = 0;
  int      fall_tot = 0;
  int      r_dbl = 0, r_main = 0, r_half = 0;
  logic    p_dbl = 1'b0, p_main = 1'b0, p_half = 1'b0;
  logic    p_test = 1'b0;
  logic    p_fsel = 1'b0;
  bit      percycle_on = 1'b1;

  always @(posedge clk) begin
    logic sel, fell, e_dbl, e_main, e_half;
    logic [2:0] k;
    #3;
    sel  = ref_sel ? sync1 : sync0;
    fell = (prev_sel === 1'b1) && (sel === 1'b0);
    if (fell) begin
      fall_tot++;
      if (rst) begin
        falls  = 0;
        cnt_ok = 1'b1;
      end else begin
        falls++;
      end
    end
    k = falls[2:0];
    if (fsel) begin
      e_dbl = ~sel; e_main = k[0]; e_half = k[1];
    end else begin
      e_dbl = k[0]; e_main = k[1]; e_half = k[2];
    end
    if (pll_en) begin
      e_dbl = pll_dbl; e_main = pll_main[0]; e_half = pll_half;
    end
    if (cnt_ok && percycle_on) begin
      if (pll_en) begin
        chk("R2", {dbl_q, main_q, half_q}, {pll_dbl, pll_main, pll_half});
      end else if (fsel) begin
        chk(ref_sel ? "R3 R1" : "R3", dbl_q, e_dbl);
        chk("R4 R8 R10", main_q, {NM{e_main}});
        chk("R4 R10", half_q, e_half);
      end else begin
        chk(ref_sel ? "R5 R1" : "R5", dbl_q, e_dbl);
        chk("R5 R8 R10", main_q, {NM{e_main}});
        chk("R5 R10", half_q, e_half);
      end
      // R6: without a fall, divided outputs hold in an unchanged test mode
      if (!fell && !pll_en && p_test && fsel == p_fsel)
        chk("R6", {main_q[0], half_q}, {p_main, p_half});
    end
    if (dbl_q && !p_dbl)     r_dbl++;
    if (main_q[0] && !p_main) r_main++;
    if (half_q && !p_half)   r_half++;
    p_dbl = dbl_q; p_main = main_q[0]; p_half = half_q;
    p_test = !pll_en; p_fsel = fsel;
    prev_sel = sel;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_falls(input int n);
    int start;
    start = fall_tot;
    while (fall_tot - start < n) @(posedge clk);
    step(1);
  endtask

  // Reset, release, run n falls, then compare counted rising edges
  task automatic ratio(input string tag, input int n,
                       input int e_d, input int e_m, input int e_h);
    rst = 1'b1;
    wait_falls(2);
    // release just after a fall so the window starts at count 0
    while (!(((ref_sel ? sync1 : sync0)) == 1'b0 && prev_sel == 1'b0)) step(1);
    rst = 1'b0;
    r_dbl = 0; r_main = 0; r_half = 0;
    wait_falls(n);
    // window may end mid-phase; only divided outputs compared exactly after n falls
    chk({tag, " dbl rises"}, r_dbl, e_d);
    chk({tag, " main rises"}, r_main, e_m);
    chk({tag, " half rises"}, r_half, e_h);
  endtask

  initial begin : watchdog
    #1500000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    step(2);
    wait_falls(2);
    // R7: reset state in test mode, divide-by-8 setting
    ctx = "reset";
    chk("R7", {dbl_q, main_q, half_q}, '0);
    rst = 1'b0;
    ctx = "run lo sync0";
    wait_falls(21);
    ctx = "fsel switch mid-count";
    fsel = 1'b1;
    wait_falls(13);
    fsel = 1'b0;
    wait_falls(7);
    ctx = "pll bypass";
    pll_en = 1'b1;
    pll_main = 5'b10110; pll_dbl = 1'b1; pll_half = 1'b0;
    step(3);
    pll_main = 5'b01001; pll_dbl = 1'b0; pll_half = 1'b1;
    wait_falls(5);
    pll_en = 1'b0;
    ctx = "after bypass";
    wait_falls(9);
    ctx = "reset during run";
    rst = 1'b1;
    wait_falls(1);
    chk("R7", {main_q, half_q, dbl_q}, '0);
    // switch source only under reset
    ref_sel = 1'b1;
    wait_falls(2);
    rst = 1'b0;
    ctx = "run lo sync1";
    wait_falls(19);
    fsel = 1'b1;
    ctx = "run hi sync1";
    wait_falls(11);
    // R9 ratio windows: rises counted over 160 falls from count 0
    percycle_on = 1'b0;
    ctx = "ratio";
    fsel = 1'b0;
    ratio("R5 R9 R1 sync1", 160, 80, 40, 20);
    fsel = 1'b1;
    ratio("R4 R9 R1 sync1", 160, 160, 80, 40);
    rst = 1'b1;
    ref_sel = 1'b0;
    wait_falls(2);
    fsel = 1'b0;
    ratio("R5 R9 sync0", 160, 80, 40, 20);
    fsel = 1'b1;
    ratio("R4 R9 sync0", 160, 160, 80, 40);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule